// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block adds two 20-bit operands and a carry-in with no clock. The result is a 20-bit sum and a carry-out. The word is split into five blocks. Their widths grow by one bit per block, starting at the least significant end. The block for bits 0 to 1 is a plain ripple adder fed straight from the external carry-in.

Each of the four upper blocks computes its sum bits and carry-out twice, at the same time: once assuming a carry-in of 0 and once assuming a carry-in of 1. When the real carry reaches the block, it steers a multiplexer that picks one of the two results. The selected carry-out then becomes the select input of the next block.

Wider blocks sit further up the chain, where the select carry arrives later. A longer internal ripple there costs no extra delay. Inside every block, each bit first forms generate (a AND b) and propagate (a XOR b). Carries ripple as generate OR (propagate AND incoming carry), and each sum bit is propagate XOR incoming carry.

Top module: `sqrt_csel_adder`

## Requirements
- R1: The concatenation {carryOut, sumOut} equals opA + opB + carryIn as an unsigned 21-bit value, for every input combination.
- R2: The blocks cover bits 0–1, 2–4, 5–8, 9–13 and 14–19, and each block by itself produces the exact sum of its operand slice plus its own carry-in.
- R3: The lowest block takes carryIn directly. With carryIn = 1 and both operands zero, sumOut is 1. With opA bits 0–1 all ones, opB zero and carryIn = 1, the carry crosses into bit 2.
- R4: In each upper block, the result pair computed for an assumed carry-in of 1 equals the pair computed for an assumed carry-in of 0, plus one, taken as a (width+1)-bit value.
- R5: Each block boundary (bits 2, 5, 9, 14) gives the correct result both when its arriving carry is 0 and when it is 1. This is tested with operands that are all ones below the boundary and zero above it.
- R6: carryOut is the selected carry-out of the bits 14–19 block. It is 1 exactly when the true 21-bit sum reaches 2^20. A carry that enters at bit 0 and propagates through every bit must reach carryOut.
- R7: With every bit generating (both operands all ones), sumOut is all ones when carryIn is 1, and 0xFFFFE when carryIn is 0. carryOut is 1 in both cases.
- R8: With all inputs zero, sumOut and carryOut are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 20 | First addend |
| opB | input | 20 | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 20 | Sum bits |
| carryOut | output | 1 | Carry out of bit 19 |

## Verification
The embedded checks are immediate and combinational. They take for granted that the inputs hold known two-state values whenever the outputs are evaluated. They also assume the comparison happens only after the inputs have settled.

The stimulus therefore changes operands and carry-in just after each rising edge. Results are read at the falling edge, so every sampled value comes from a fully settled ripple.

Beyond random operands, the stimulus uses runs of ones that end exactly below each block boundary. Each boundary is then driven with both carry values. It also uses the fully propagating and fully generating operand pairs.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int DEF_FIRST_WIDTH = 2;
  localparam int DEF_NUM_BLOCKS  = 5;

  // Least significant bit of block idx when widths grow by one per block.
  function automatic int blockLsb(input int idx, input int firstWidth);
    return idx * firstWidth + (idx * (idx - 1)) / 2;
  endfunction

  function automatic int totalWidth(input int numBlocks, input int firstWidth);
    return blockLsb(numBlocks, firstWidth);
  endfunction
endpackage

// File: rtl/csa_ripple_block.sv
module csa_ripple_block #(
  parameter int Width = 2
) (
  input  logic [Width-1:0] aIn,
  input  logic [Width-1:0] bIn,
  input  logic             cIn,
  output logic [Width-1:0] sumOut,
  output logic             cOut
);
  logic [Width-1:0] genBit;
  logic [Width-1:0] propBit;
  logic [Width:0]   carryChain;

  assign carryChain[0] = cIn;

  for (genvar k = 0; k < Width; k++) begin : g_bit
    assign genBit[k]        = aIn[k] & bIn[k];
    assign propBit[k]       = aIn[k] ^ bIn[k];
    assign carryChain[k+1]  = genBit[k] | (propBit[k] & carryChain[k]);
    assign sumOut[k]        = propBit[k] ^ carryChain[k];
  end

  assign cOut = carryChain[Width];

  logic [Width:0] sliceRef;
  always_comb begin
    sliceRef = {1'b0, aIn} + {1'b0, bIn} + {{Width{1'b0}}, cIn};
    assert_block_exact_R2: assert ({cOut, sumOut} == sliceRef)
      else $error("R2: ripple block result mismatch");
  end
endmodule

// File: rtl/csa_select_block.sv
module csa_select_block #(
  parameter int Width = 3
) (
  input  logic [Width-1:0] aIn,
  input  logic [Width-1:0] bIn,
  input  logic             selCarry,
  output logic [Width-1:0] sumOut,
  output logic             cOut
);
  logic [Width-1:0] sumIfZero;
  logic [Width-1:0] sumIfOne;
  logic             coutIfZero;
  logic             coutIfOne;

  csa_ripple_block #(.Width(Width)) i_pathZero (
    .aIn(aIn), .bIn(bIn), .cIn(1'b0), .sumOut(sumIfZero), .cOut(coutIfZero)
  );

  csa_ripple_block #(.Width(Width)) i_pathOne (
    .aIn(aIn), .bIn(bIn), .cIn(1'b1), .sumOut(sumIfOne), .cOut(coutIfOne)
  );

  assign sumOut = selCarry ? sumIfOne : sumIfZero;
  assign cOut   = selCarry ? coutIfOne : coutIfZero;

  always_comb begin
    assert_plus_one_R4: assert ({coutIfOne, sumIfOne} == {coutIfZero, sumIfZero} + (Width+1)'(1))
      else $error("R4: assumed-one path is not assumed-zero path plus one");
    assert_carry_monotone_R4: assert (!coutIfZero || coutIfOne)
      else $error("R4: carry with assumed 0 but not with assumed 1");
  end
endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder #(
  parameter  int FirstWidth = csa_pkg::DEF_FIRST_WIDTH,
  parameter  int NumBlocks  = csa_pkg::DEF_NUM_BLOCKS,
  localparam int DataWidth  = csa_pkg::totalWidth(NumBlocks, FirstWidth)
) (
  input  logic [DataWidth-1:0] opA,
  input  logic [DataWidth-1:0] opB,
  input  logic                 carryIn,
  output logic [DataWidth-1:0] sumOut,
  output logic                 carryOut
);
  logic [NumBlocks:0] blockCarry;

  assign blockCarry[0] = carryIn;

  for (genvar i = 0; i < NumBlocks; i++) begin : g_block
    localparam int Lsb = csa_pkg::blockLsb(i, FirstWidth);
    localparam int Wid = FirstWidth + i;
    if (i == 0) begin : g_ripple
      csa_ripple_block #(.Width(Wid)) i_first (
        .aIn(opA[Lsb +: Wid]), .bIn(opB[Lsb +: Wid]), .cIn(blockCarry[i]),
        .sumOut(sumOut[Lsb +: Wid]), .cOut(blockCarry[i+1])
      );
    end else begin : g_select
      csa_select_block #(.Width(Wid)) i_sel (
        .aIn(opA[Lsb +: Wid]), .bIn(opB[Lsb +: Wid]), .selCarry(blockCarry[i]),
        .sumOut(sumOut[Lsb +: Wid]), .cOut(blockCarry[i+1])
      );
    end
  end

  assign carryOut = blockCarry[NumBlocks];

  logic [DataWidth:0] wordRef;
  always_comb begin
    wordRef = {1'b0, opA} + {1'b0, opB} + {{DataWidth{1'b0}}, carryIn};
    assert_sum_exact_R1: assert ({carryOut, sumOut} == wordRef)
      else $error("R1: adder result mismatch");
    assert_carry_out_R6: assert (carryOut == wordRef[DataWidth])
      else $error("R6: carry-out mismatch");
  end
endmodule

// File: tb/test_sqrt_csel_adder.sv
module test_sqrt_csel_adder;
  localparam int W = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] opA = '0, opB = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] sumOut;
  logic         carryOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sqrt_csel_adder i_sqrt_csel_adder (
    .opA(opA), .opB(opB), .carryIn(carryIn), .sumOut(sumOut), .carryOut(carryOut)
  );

  // Drive after a rising edge, compare with a behavioural sum at the falling edge.
  task automatic apply(input string tag, input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    longint unsigned expv;
    longint unsigned got;
    @(posedge clk); #1;
    opA = a; opB = b; carryIn = c;
    @(negedge clk);
    expv = longint'(a) + longint'(b) + longint'(c);
    got  = {43'd0, carryOut, sumOut};
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s: a=%h b=%h c=%0d actual=%h expected=%h", tag, a, b, c, got, expv);
    end
  endtask

  initial begin
    int bounds[4] = '{2, 5, 9, 14};
    // R8: all-zero inputs
    apply("R8", '0, '0, 1'b0);
    // R3: carry-in enters the first block directly and crosses into bit 2
    apply("R3", '0, '0, 1'b1);
    apply("R3", 20'h00003, '0, 1'b1);
    // R5 / R2: each boundary receives carry 0 and carry 1
    foreach (bounds[k]) begin
      logic [W-1:0] low = (20'd1 << bounds[k]) - 20'd1;
      apply("R5", low, '0, 1'b0);
      apply("R5", low, '0, 1'b1);
      apply("R2", low, 20'd1 << bounds[k], 1'b1);
      apply("R2", low >> 1, low >> 1, 1'b1);
    end
    // R6: full propagate chain reaches carryOut
    apply("R6", '1, '0, 1'b1);
    apply("R6", 20'hAAAAA, 20'h55555, 1'b1);
    apply("R6", 20'hAAAAA, 20'h55555, 1'b0);
    // R7: every bit generates
    apply("R7", '1, '1, 1'b1);
    apply("R7", '1, '1, 1'b0);
    // R1: random operands
    for (int n = 0; n < 400; n++) begin
      apply("R1", W'($urandom), W'($urandom), 1'($urandom));
    end
    // R4: operands whose blocks are internally all-propagate, so both paths differ
    for (int n = 0; n < 50; n++) begin
      logic [W-1:0] r = W'($urandom);
      apply("R4", r, ~r, 1'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule